// File: doc/BRIEF.md
# Hypervisor System Register Access Gate

This block decides what happens when software tries to read or write one 64-bit, hypervisor-owned trap-control system register. A request arrives as a one-cycle strobe. It carries five fields that together identify the register (op0, op1, CRn, CRm, op2), a read/write flag, write data and the privilege level of the requester. The block also sees the current virtualization and security controls: whether the hypervisor is enabled, the two nested-virtualization bits, whether a monitor level exists, the monitor's fine-grained trap enable, a halted-debug flag and a secure-debug-disable flag.

One cycle after the strobe, the block returns one of four outcomes:
- perform the access on the register it holds;
- report the instruction as undefined;
- trap to a higher level, with a syndrome code;
- redirect the access to a fixed memory offset.

Moving data to memory and entering the exception are left to the surrounding pipeline.

A parameter selects what wins when the core is halted with secure debug disabled and a monitor trap is otherwise due. With the default setting, the undefined result takes precedence. With the other setting, the monitor trap still applies.

Top module: `sreg_access_ctl`

## Requirements
- R1: A request is recognised only when op0=2'b11, op1=3'b100, CRn=4'b0001, CRm=4'b0001 and op2=3'b110. Any other identifier produces no response, with rsp_valid low in the following cycle, and leaves the stored register unchanged.
- R2: For a recognised request, rsp_valid is high for exactly one cycle, the cycle after the strobe. rsp_kind is encoded 0=access, 1=undefined, 2=trap, 3=redirect.
- R3: Every request from level 0 (req_el=0) gives undefined.
- R4: At level 1, when hyp_en, nv_base and nv_ext are all 1, the result is redirect with rsp_offset=0x1C8.
- R5: At level 1, when hyp_en=1, nv_base=1 and nv_ext=0, the result is trap with rsp_target_el=2 and rsp_code=0x18. Every other level-1 combination gives undefined.
- R6: At level 2, when mon_present=1 and mon_fgt_en=0, and the core is not both halted and under secure debug disable, the result is trap with rsp_target_el=3 and rsp_code=0x18.
- R7: At level 2, when mon_present=1, mon_fgt_en=0, halted=1 and sec_dbg_dis=1:
  - with UNDEF_BEATS_MON=1 the result is undefined;
  - with UNDEF_BEATS_MON=0 the result is the level-3 trap of R6.
- R8: At level 2 with mon_fgt_en=1 or mon_present=0, and at level 3 in every case, the result is access. A write stores req_wdata. A read returns the stored value as it was before that cycle's edge.
- R9: After reset, rsp_valid is 0 and the stored register reads as zero.
- R10: A result other than access never changes the stored register and returns rsp_rdata=0. A write that is performed also returns rsp_rdata=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op0 | input | 2 | Identifier field op0 |
| req_op1 | input | 3 | Identifier field op1 |
| req_crn | input | 4 | Identifier field CRn |
| req_crm | input | 4 | Identifier field CRm |
| req_op2 | input | 3 | Identifier field op2 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_el | input | 2 | Privilege level of the requester (0..3) |
| req_wdata | input | DATA_W | Write data |
| hyp_en | input | 1 | Hypervisor enabled in the current security state |
| nv_base | input | 1 | Base nested-virtualization control |
| nv_ext | input | 1 | Extended nested-virtualization control |
| mon_present | input | 1 | A monitor level exists |
| mon_fgt_en | input | 1 | Monitor enable for fine-grained traps |
| halted | input | 1 | Core is in halted debug |
| sec_dbg_dis | input | 1 | Secure debug is disabled |
| rsp_valid | output | 1 | Response valid pulse |
| rsp_kind | output | 2 | Outcome: 0 access, 1 undefined, 2 trap, 3 redirect |
| rsp_target_el | output | 2 | Level that a trap is taken to |
| rsp_code | output | CODE_W | Trap syndrome code |
| rsp_offset | output | OFFS_W | Memory offset for a redirect |
| rsp_rdata | output | DATA_W | Read data for an access that is a read |

## Verification
The bench builds two copies of the block with the default widths, one with UNDEF_BEATS_MON=1 and one with UNDEF_BEATS_MON=0. Both copies receive the same stimulus. The sweep covers all four levels, all 128 combinations of the seven control inputs and both directions. This makes the halted-debug precedence for both parameter values reachable in a single run, and every write is checked by the reads that follow it. A second sweep flips each bit of the 16-bit identifier in turn. It confirms that each non-matching request stays silent and does not alter the stored register.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  typedef enum logic [1:0] {
    RES_ACCESS = 2'd0,
    RES_UNDEF  = 2'd1,
    RES_TRAP   = 2'd2,
    RES_REDIR  = 2'd3
  } res_kind_e;

  typedef struct packed {
    logic [1:0] op0;
    logic [2:0] op1;
    logic [3:0] crn;
    logic [3:0] crm;
    logic [2:0] op2;
  } sreg_id_t;

  localparam sreg_id_t GATED_REG_ID = '{op0: 2'b11, op1: 3'b100, crn: 4'b0001,
                                        crm: 4'b0001, op2: 3'b110};

  localparam logic [1:0] LVL_USER  = 2'd0;
  localparam logic [1:0] LVL_KERN  = 2'd1;
  localparam logic [1:0] LVL_HYP   = 2'd2;
  localparam logic [1:0] LVL_MON   = 2'd3;

endpackage

// File: rtl/sreg_id_match.sv
module sreg_id_match
  import sreg_pkg::*;
#(
  parameter sreg_id_t MATCH_ID = GATED_REG_ID
) (
  input  sreg_id_t id,
  output logic     hit
);
  localparam int FIELD_W = $bits(sreg_id_t);
  logic [FIELD_W-1:0] diff;

  assign diff = id ^ MATCH_ID;
  assign hit  = (diff == '0);
endmodule

// File: rtl/sreg_policy.sv
module sreg_policy
  import sreg_pkg::*;
#(
  parameter int          CODE_W          = 6,
  parameter int          OFFS_W          = 12,
  parameter logic [CODE_W-1:0] TRAP_CODE = 6'h18,
  parameter logic [OFFS_W-1:0] REDIR_OFFS = 12'h1C8,
  parameter bit          UNDEF_BEATS_MON = 1'b1
) (
  input  logic [1:0]        el,
  input  logic              hyp_en,
  input  logic              nv_base,
  input  logic              nv_ext,
  input  logic              mon_present,
  input  logic              mon_fgt_en,
  input  logic              halted,
  input  logic              sec_dbg_dis,
  output res_kind_e         kind,
  output logic [1:0]        target_el,
  output logic [CODE_W-1:0] code,
  output logic [OFFS_W-1:0] offset
);
  logic halt_forces_undef;
  logic mon_trap_due;

  assign halt_forces_undef = halted & sec_dbg_dis & UNDEF_BEATS_MON;
  assign mon_trap_due      = mon_present & ~mon_fgt_en;

  always_comb begin
    kind      = RES_UNDEF;
    target_el = 2'd0;
    code      = '0;
    offset    = '0;
    unique case (el)
      LVL_USER: kind = RES_UNDEF;
      LVL_KERN: begin
        if (hyp_en && nv_base) begin
          if (nv_ext) begin
            kind   = RES_REDIR;
            offset = REDIR_OFFS;
          end else begin
            kind      = RES_TRAP;
            target_el = LVL_HYP;
            code      = TRAP_CODE;
          end
        end
      end
      LVL_HYP: begin
        if (mon_trap_due) begin
          if (halt_forces_undef) begin
            kind = RES_UNDEF;
          end else begin
            kind      = RES_TRAP;
            target_el = LVL_MON;
            code      = TRAP_CODE;
          end
        end else begin
          kind = RES_ACCESS;
        end
      end
      default: kind = RES_ACCESS;
    endcase
  end
endmodule

// File: rtl/sreg_store.sv
module sreg_store #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] value_q;

  always_ff @(posedge clk) begin
    if (rst) value_q <= '0;
    else if (we) value_q <= wdata;
  end

  assign q = value_q;
endmodule

// File: rtl/sreg_access_ctl.sv
module sreg_access_ctl
  import sreg_pkg::*;
#(
  parameter int                DATA_W          = 64,
  parameter int                CODE_W          = 6,
  parameter int                OFFS_W          = 12,
  parameter logic [CODE_W-1:0] TRAP_CODE       = 6'h18,
  parameter logic [OFFS_W-1:0] REDIR_OFFS      = 12'h1C8,
  parameter bit                UNDEF_BEATS_MON = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op0,
  input  logic [2:0]        req_op1,
  input  logic [3:0]        req_crn,
  input  logic [3:0]        req_crm,
  input  logic [2:0]        req_op2,
  input  logic              req_write,
  input  logic [1:0]        req_el,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              hyp_en,
  input  logic              nv_base,
  input  logic              nv_ext,
  input  logic              mon_present,
  input  logic              mon_fgt_en,
  input  logic              halted,
  input  logic              sec_dbg_dis,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [1:0]        rsp_target_el,
  output logic [CODE_W-1:0] rsp_code,
  output logic [OFFS_W-1:0] rsp_offset,
  output logic [DATA_W-1:0] rsp_rdata
);
  sreg_id_t          req_id;
  logic              id_hit;
  logic              accept;
  res_kind_e         dec_kind;
  logic [1:0]        dec_target;
  logic [CODE_W-1:0] dec_code;
  logic [OFFS_W-1:0] dec_offset;
  logic              store_we;
  logic [DATA_W-1:0] store_q;

  assign req_id = '{op0: req_op0, op1: req_op1, crn: req_crn, crm: req_crm, op2: req_op2};

  sreg_id_match #(.MATCH_ID(GATED_REG_ID)) u_match (
    .id  (req_id),
    .hit (id_hit)
  );

  sreg_policy #(
    .CODE_W          (CODE_W),
    .OFFS_W          (OFFS_W),
    .TRAP_CODE       (TRAP_CODE),
    .REDIR_OFFS      (REDIR_OFFS),
    .UNDEF_BEATS_MON (UNDEF_BEATS_MON)
  ) u_policy (
    .el          (req_el),
    .hyp_en      (hyp_en),
    .nv_base     (nv_base),
    .nv_ext      (nv_ext),
    .mon_present (mon_present),
    .mon_fgt_en  (mon_fgt_en),
    .halted      (halted),
    .sec_dbg_dis (sec_dbg_dis),
    .kind        (dec_kind),
    .target_el   (dec_target),
    .code        (dec_code),
    .offset      (dec_offset)
  );

  assign accept   = req_valid & id_hit;
  assign store_we = accept & req_write & (dec_kind == RES_ACCESS);

  sreg_store #(.DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (store_we),
    .wdata (req_wdata),
    .q     (store_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_kind      <= RES_ACCESS;
      rsp_target_el <= 2'd0;
      rsp_code      <= '0;
      rsp_offset    <= '0;
      rsp_rdata     <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_kind      <= dec_kind;
        rsp_target_el <= dec_target;
        rsp_code      <= dec_code;
        rsp_offset    <= dec_offset;
        rsp_rdata     <= (dec_kind == RES_ACCESS && !req_write) ? store_q : '0;
      end
    end
  end
endmodule

// File: rtl/sreg_access_ctl_chk.sv
module sreg_access_ctl_chk #(
  parameter int                DATA_W     = 64,
  parameter int                CODE_W     = 6,
  parameter int                OFFS_W     = 12,
  parameter logic [CODE_W-1:0] TRAP_CODE  = 6'h18,
  parameter logic [OFFS_W-1:0] REDIR_OFFS = 12'h1C8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_op0,
  input logic [2:0]        req_op1,
  input logic [3:0]        req_crn,
  input logic [3:0]        req_crm,
  input logic [2:0]        req_op2,
  input logic [1:0]        req_el,
  input logic              rsp_valid,
  input logic [1:0]        rsp_kind,
  input logic [1:0]        rsp_target_el,
  input logic [CODE_W-1:0] rsp_code,
  input logic [OFFS_W-1:0] rsp_offset,
  input logic [DATA_W-1:0] rsp_rdata
);
  logic id_ok;
  assign id_ok = (req_op0 == 2'b11) && (req_op1 == 3'b100) && (req_crn == 4'b0001) &&
                 (req_crm == 4'b0001) && (req_op2 == 3'b110);

  // R1: unknown identifier never answers
  p_nomatch_silent_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !id_ok) |=> !rsp_valid);

  // R2: no strobe, no response
  p_pulse_only_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R3
  p_user_undef_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && id_ok && req_el == 2'd0) |=> (rsp_valid && rsp_kind == 2'd1));

  // R4
  p_redir_offset_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == 2'd3) |-> (rsp_offset == REDIR_OFFS));

  // R5 / R6: any trap goes upward with the fixed code
  p_trap_code_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == 2'd2) |-> (rsp_code == TRAP_CODE && rsp_target_el >= 2'd2));

  // R8
  p_mon_access_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && id_ok && req_el == 2'd3) |=> (rsp_valid && rsp_kind == 2'd0));

  // R10
  p_rdata_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind != 2'd0) |-> (rsp_rdata == '0));
endmodule

bind sreg_access_ctl sreg_access_ctl_chk #(
  .DATA_W     (DATA_W),
  .CODE_W     (CODE_W),
  .OFFS_W     (OFFS_W),
  .TRAP_CODE  (TRAP_CODE),
  .REDIR_OFFS (REDIR_OFFS)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_op0       (req_op0),
  .req_op1       (req_op1),
  .req_crn       (req_crn),
  .req_crm       (req_crm),
  .req_op2       (req_op2),
  .req_el        (req_el),
  .rsp_valid     (rsp_valid),
  .rsp_kind      (rsp_kind),
  .rsp_target_el (rsp_target_el),
  .rsp_code      (rsp_code),
  .rsp_offset    (rsp_offset),
  .rsp_rdata     (rsp_rdata)
);

// File: tb/sreg_access_ctl_tb_top.sv
module sreg_access_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_op0 = 2'b11;
  logic [2:0] req_op1 = 3'b100;
  logic [3:0] req_crn = 4'b0001;
  logic [3:0] req_crm = 4'b0001;
  logic [2:0] req_op2 = 3'b110;
  logic req_write = 1'b0;
  logic [1:0] req_el = 2'd3;
  logic [DW-1:0] req_wdata = '0;
  logic hyp_en = 0, nv_base = 0, nv_ext = 0, mon_present = 0;
  logic mon_fgt_en = 0, halted = 0, sec_dbg_dis = 0;

  logic a_valid, b_valid;
  logic [1:0] a_kind, b_kind, a_tgt, b_tgt;
  logic [5:0] a_code, b_code;
  logic [11:0] a_offs, b_offs;
  logic [DW-1:0] a_rdata, b_rdata;

  int checks = 0;
  int fails = 0;
  logic done = 1'b0;
  logic [DW-1:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sreg_access_ctl #(.UNDEF_BEATS_MON(1'b1)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op0(req_op0), .req_op1(req_op1),
    .req_crn(req_crn), .req_crm(req_crm), .req_op2(req_op2), .req_write(req_write),
    .req_el(req_el), .req_wdata(req_wdata), .hyp_en(hyp_en), .nv_base(nv_base),
    .nv_ext(nv_ext), .mon_present(mon_present), .mon_fgt_en(mon_fgt_en), .halted(halted),
    .sec_dbg_dis(sec_dbg_dis), .rsp_valid(a_valid), .rsp_kind(a_kind),
    .rsp_target_el(a_tgt), .rsp_code(a_code), .rsp_offset(a_offs), .rsp_rdata(a_rdata));

  sreg_access_ctl #(.UNDEF_BEATS_MON(1'b0)) dut_alt_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op0(req_op0), .req_op1(req_op1),
    .req_crn(req_crn), .req_crm(req_crm), .req_op2(req_op2), .req_write(req_write),
    .req_el(req_el), .req_wdata(req_wdata), .hyp_en(hyp_en), .nv_base(nv_base),
    .nv_ext(nv_ext), .mon_present(mon_present), .mon_fgt_en(mon_fgt_en), .halted(halted),
    .sec_dbg_dis(sec_dbg_dis), .rsp_valid(b_valid), .rsp_kind(b_kind),
    .rsp_target_el(b_tgt), .rsp_code(b_code), .rsp_offset(b_offs), .rsp_rdata(b_rdata));

  // Expected outcome from the requirements: {kind, target, code, offset}
  function automatic logic [21:0] expect_res(input logic [1:0] el, input logic [6:0] c,
                                             input bit beats);
    logic h, nb, ne, mp, fe, hl, sd;
    {h, nb, ne, mp, fe, hl, sd} = c;
    case (el)
      2'd0: return {2'd1, 2'd0, 6'd0, 12'd0};                        // R3
      2'd1: if (h && nb && ne) return {2'd3, 2'd0, 6'd0, 12'h1C8};   // R4
            else if (h && nb) return {2'd2, 2'd2, 6'h18, 12'd0};      // R5
            else return {2'd1, 2'd0, 6'd0, 12'd0};                    // R5
      2'd2: if (mp && !fe) begin
              if (hl && sd && beats) return {2'd1, 2'd0, 6'd0, 12'd0}; // R7
              else return {2'd2, 2'd3, 6'h18, 12'd0};                  // R6 / R7
            end else return {2'd0, 2'd0, 6'd0, 12'd0};                 // R8
      default: return {2'd0, 2'd0, 6'd0, 12'd0};                       // R8
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] el, input logic [6:0] c);
    if (el == 2'd0) return "R3";
    if (el == 2'd1) return c[4] ? "R4" : "R5";
    if (el == 2'd2) begin
      if (c[3] && !c[2]) return (c[1] && c[0]) ? "R7" : "R6";
      return "R8";
    end
    return "R8";
  endfunction

  task automatic check_one(input string who, input string tag, input logic v,
                           input logic [21:0] got, input logic [DW-1:0] rd,
                           input logic [21:0] exp, input logic [DW-1:0] exp_rd);
    logic [21:0] mask;
    mask = 22'h3C0000;
    if (exp[21:20] == 2'd2) mask = mask | 22'h03F000;
    if (exp[21:20] == 2'd3) mask = mask | 22'h000FFF;
    checks++;
    if (!v || ((got & mask) != (exp & mask)) || rd != exp_rd) begin
      fails++;
      $display("FAIL %s %s: valid=%0b res=%h rdata=%h expected valid=1 res=%h rdata=%h",
               tag, who, v, got & mask, rd, exp & mask, exp_rd);
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    checks++;
    if (a_valid || b_valid) begin
      fails++;
      $display("FAIL R2 pulse longer than one cycle: valid=%0b/%0b expected 0/0",
               a_valid, b_valid);
    end
  endtask

  task automatic run_req(input logic [1:0] el, input logic [6:0] c, input logic wr,
                         input logic [DW-1:0] wd);
    logic [21:0] ea, eb;
    logic [DW-1:0] erd;
    string t;
    req_el = el; {hyp_en, nv_base, nv_ext, mon_present, mon_fgt_en, halted, sec_dbg_dis} = c;
    req_write = wr; req_wdata = wd; req_valid = 1'b1;
    ea = expect_res(el, c, 1'b1);
    eb = expect_res(el, c, 1'b0);
    erd = (ea[21:20] == 2'd0 && !wr) ? model : '0;                      // R8 / R10
    t = tag_of(el, c);
    @(negedge clk);
    req_valid = 1'b0;
    check_one("undef-wins", t, a_valid, {a_kind, a_tgt, a_code, a_offs}, a_rdata, ea, erd);
    check_one("trap-wins", t, b_valid, {b_kind, b_tgt, b_code, b_offs}, b_rdata, eb, erd);
    if (ea[21:20] == 2'd0 && wr) model = wd;
    idle_check();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    checks++;
    if (a_valid || b_valid) begin
      fails++;
      $display("FAIL R9 valid after reset=%0b/%0b expected 0/0", a_valid, b_valid);
    end
    run_req(2'd3, 7'd0, 1'b0, '0);                                       // R9 reads zero

    // Full sweep R3..R8, R10
    for (int el = 0; el < 4; el++)
      for (int c = 0; c < 128; c++)
        for (int wr = 0; wr < 2; wr++)
          run_req(2'(el), 7'(c), 1'(wr),
                  64'h9E3779B97F4A7C15 * 64'(el * 256 + c * 2 + wr + 1));

    // R1: each single-bit identifier change is silent and does not store
    for (int b = 0; b < 16; b++) begin
      logic [15:0] id;
      id = {2'b11, 3'b100, 4'b0001, 4'b0001, 3'b110} ^ (16'd1 << b);
      {req_op0, req_op1, req_crn, req_crm, req_op2} = id;
      req_el = 2'd3; req_write = 1'b1; req_wdata = 64'hDEAD_0000_0000_0000 | 64'(b);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      checks++;
      if (a_valid || b_valid) begin
        fails++;
        $display("FAIL R1 id=%h answered valid=%0b/%0b expected 0/0", id, a_valid, b_valid);
      end
      {req_op0, req_op1, req_crn, req_crm, req_op2} = {2'b11, 3'b100, 4'b0001, 4'b0001, 3'b110};
      run_req(2'd3, 7'd0, 1'b0, '0);                                     // R1 storage unchanged
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG_CYCLES) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule